// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a synchronous host and an external asynchronous static RAM. The host issues one single-word request at a time through a valid/ready port. A request carries an address, a write flag and write data. The controller turns each request into registered chip-enable, output-enable and write-enable strobes, an address, and a split data bus made of an output value, an output-enable and an input value. The tri-state buffer itself sits in the pad ring.

Every strobe phase is a whole number of clock cycles. Each phase length is derived at elaboration time from nanosecond timing limits and the clock period. After reset the controller issues nothing until a power-up settle interval has elapsed.

Writes are controlled by write enable. The data bus is driven only after the memory's output turn-off time. It is then held one cycle beyond the end of the write, so the bus turns around cleanly in both directions. Read data returns on a one-cycle response pulse.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset release, `req_ready` stays 0, all three strobes stay high and `sram_dq_oe` stays 0 until the clock edge numbered PWR+1, where PWR = ceil(T_POWERUP_NS / CLK_PERIOD_NS); `req_ready` is 1 from that edge on.
- R2: Phase lengths in cycles use c(t) = ceil(t / CLK_PERIOD_NS), with a minimum of 1. Read phase RD is the largest of c(read cycle), c(address access) and c(output-enable access). Turn-off phase HZ is c(write-enable-to-high-Z). Data phase DAT is the larger of c(data setup) and (the largest of c(write pulse), c(chip-enable-to-write-end), c(address-to-write-end), c(write cycle)) − HZ.
- R3: A read is accepted on an edge where `req_valid`, `req_ready` and `!req_write` hold. `sram_ce_n` and `sram_oe_n` are then low for exactly RD cycles. The value on `sram_dq_i` in the last of those cycles appears on `rsp_rdata`, with `rsp_valid` high for exactly the one following cycle.
- R4: An accepted write drives `sram_we_n` and `sram_ce_n` low for exactly HZ+DAT cycles, starting in the cycle after acceptance. `sram_oe_n` stays high throughout the write.
- R5: During a write, `sram_dq_oe` is 0 for the first HZ cycles of the write-enable pulse. It is then 1, with `sram_dq_o` equal to the request's write data, for the last DAT cycles before `sram_we_n` rises.
- R6: After `sram_we_n` rises, `sram_dq_oe` stays 1 for exactly one cycle with both enables high, then returns to 0. `sram_dq_oe` is 0 in every cycle outside a write.
- R7: `req_ready` is 1 only while no access is in progress. A request presented while `req_ready` is 0 is ignored: it changes neither the strobes nor the address.
- R8: `sram_ce_n` is high whenever no access is in progress. `sram_addr` equals the accepted request's address for the whole access.
- R9: `sram_oe_n` and `sram_we_n` are never low together, and the controller never drives the bus while the memory's outputs are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Captured read data |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq_o | output | DATA_W | Data toward the memory |
| sram_dq_oe | output | 1 | Pad drive enable for `sram_dq_o` |
| sram_dq_i | input | DATA_W | Data from the memory |

## Verification
The assertions assume the host holds no request across reset. They also assume that `sram_dq_i` is only meaningful while the memory has its outputs enabled. The stimulus raises `req_valid` only on a falling edge while the bench's own model is idle, and drops it once the request is taken. The one exception is a deliberate stray request placed inside a busy window to exercise R7. The memory model drives `sram_dq_i` only during an enabled read and a fixed filler pattern otherwise. It also measures the write pulse, the turn-off gap and the data setup window in clock cycles against the nanosecond limits.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_READ,
        ST_WR_TURN,
        ST_WR_DATA,
        ST_WR_HOLD
    } ctrl_state_e;

    // Ceiling of t_ns / clk_ns, never below one cycle.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_pwrup_wait.sv
module sram_pwrup_wait #(
    parameter int CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic settled_o
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          settled;
    } pw_t;

    pw_t d, q;

    always_comb begin
        d = q;
        if (!q.settled) begin
            d.cnt     = q.cnt + CW'(1);
            d.settled = (q.cnt == CW'(CYCLES - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign settled_o = q.settled;

    AST_SETTLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        settled_o |=> settled_o); // R1

endmodule

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         last_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)             cnt_d = load_val_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == W'(1));

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (load_val_i != '0)); // R2

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W            = 16,
    parameter int DATA_W            = 16,
    parameter int CLK_PERIOD_NS     = 10,
    parameter int T_POWERUP_NS      = 100000,
    parameter int T_READ_CYCLE_NS   = 8,
    parameter int T_ADDR_ACCESS_NS  = 8,
    parameter int T_OE_ACCESS_NS    = 5,
    parameter int T_WRITE_CYCLE_NS  = 8,
    parameter int T_WE_PULSE_NS     = 6,
    parameter int T_CE_TO_WEND_NS   = 6,
    parameter int T_ADDR_TO_WEND_NS = 6,
    parameter int T_DATA_SETUP_NS   = 5,
    parameter int T_WE_TO_HIZ_NS    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);
    localparam int PWR_CYC = ns_to_cycles(T_POWERUP_NS, CLK_PERIOD_NS);
    localparam int RD_CYC  = imax(imax(ns_to_cycles(T_READ_CYCLE_NS, CLK_PERIOD_NS),
                                       ns_to_cycles(T_ADDR_ACCESS_NS, CLK_PERIOD_NS)),
                                  ns_to_cycles(T_OE_ACCESS_NS, CLK_PERIOD_NS));
    localparam int HZ_CYC  = ns_to_cycles(T_WE_TO_HIZ_NS, CLK_PERIOD_NS);
    localparam int WLO_CYC = imax(imax(ns_to_cycles(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                       ns_to_cycles(T_CE_TO_WEND_NS, CLK_PERIOD_NS)),
                                  imax(ns_to_cycles(T_ADDR_TO_WEND_NS, CLK_PERIOD_NS),
                                       ns_to_cycles(T_WRITE_CYCLE_NS, CLK_PERIOD_NS)));
    localparam int DAT_CYC = imax(ns_to_cycles(T_DATA_SETUP_NS, CLK_PERIOD_NS),
                                  WLO_CYC - HZ_CYC);
    localparam int MAX_PH  = imax(RD_CYC, imax(HZ_CYC, DAT_CYC));
    localparam int PH_W    = $clog2(MAX_PH + 1);

    typedef struct packed {
        ctrl_state_e       st;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rsp;
    } ctrl_t;

    ctrl_t d, q;

    logic            pwr_settled;
    logic            ph_load;
    logic [PH_W-1:0] ph_val;
    logic            ph_last;

    sram_pwrup_wait #(.CYCLES(PWR_CYC)) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .settled_o (pwr_settled)
    );

    sram_phase_cnt #(.W(PH_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ph_load),
        .load_val_i (ph_val),
        .last_o     (ph_last)
    );

    always_comb begin
        d       = q;
        d.rsp   = 1'b0;
        ph_load = 1'b0;
        ph_val  = '0;
        unique case (q.st)
            ST_PWRUP: begin
                if (pwr_settled) d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.ce_n  = 1'b0;
                    ph_load = 1'b1;
                    if (req_write) begin
                        d.st   = ST_WR_TURN;
                        d.we_n = 1'b0;
                        ph_val = PH_W'(HZ_CYC);
                    end else begin
                        d.st   = ST_READ;
                        d.oe_n = 1'b0;
                        ph_val = PH_W'(RD_CYC);
                    end
                end
            end
            ST_READ: begin
                if (ph_last) begin
                    d.rdata = sram_dq_i;
                    d.rsp   = 1'b1;
                    d.ce_n  = 1'b1;
                    d.oe_n  = 1'b1;
                    d.st    = ST_IDLE;
                end
            end
            ST_WR_TURN: begin
                if (ph_last) begin
                    d.dq_oe = 1'b1;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(DAT_CYC);
                    d.st    = ST_WR_DATA;
                end
            end
            ST_WR_DATA: begin
                if (ph_last) begin
                    d.we_n = 1'b1;
                    d.ce_n = 1'b1;
                    d.st   = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                d.dq_oe = 1'b0;
                d.st    = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_PWRUP;
            q.ce_n  <= 1'b1;
            q.oe_n  <= 1'b1;
            q.we_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign rsp_valid  = q.rsp;
    assign rsp_rdata  = q.rdata;
    assign sram_ce_n  = q.ce_n;
    assign sram_oe_n  = q.oe_n;
    assign sram_we_n  = q.we_n;
    assign sram_addr  = q.addr;
    assign sram_dq_o  = q.wdata;
    assign sram_dq_oe = q.dq_oe;

    AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_settled |-> (sram_ce_n && sram_we_n && !sram_dq_oe && !req_ready)); // R1
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R3
    AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_ce_n); // R4
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!sram_dq_oe && sram_ce_n)); // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R8
    AST_NO_OE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n)); // R9
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n); // R9

endmodule

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_bench;
    // Timing set chosen so every phase spans several cycles at 10 ns.
    localparam int EXP_PWR = 10000; // 100000 ns / 10 ns
    localparam int EXP_RD  = 3;     // max(ceil 30, ceil 25, ceil 15)
    localparam int EXP_HZ  = 2;     // ceil 12
    localparam int EXP_DAT = 3;     // max(ceil 15, max(5,4,4,4) - 2)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [15:0] sram_addr, sram_dq_o, sram_dq_i;

    always #5 clk = ~clk;

    sram_strobe_ctrl #(
        .ADDR_W(16), .DATA_W(16), .CLK_PERIOD_NS(10), .T_POWERUP_NS(100000),
        .T_READ_CYCLE_NS(30), .T_ADDR_ACCESS_NS(25), .T_OE_ACCESS_NS(15),
        .T_WRITE_CYCLE_NS(40), .T_WE_PULSE_NS(45), .T_CE_TO_WEND_NS(40),
        .T_ADDR_TO_WEND_NS(40), .T_DATA_SETUP_NS(15), .T_WE_TO_HIZ_NS(12)
    ) u_sram_strobe_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_ce_n(sram_ce_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_addr(sram_addr),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    int total = 0;
    int bad = 0;
    bit fin = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!fin) begin
            fin = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Behavioural memory with cycle-level timing checks.
    logic [15:0] mem [256];
    logic [15:0] sb  [256];
    int we_cnt = 0, drv_cnt = 0, first_drv = 0, oe_cnt = 0;
    logic [15:0] pend;
    wire mem_drive = !sram_ce_n && !sram_oe_n && sram_we_n;
    assign sram_dq_i = mem_drive ? mem[sram_addr[7:0]] : 16'hDEAD;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_ce_n && !sram_we_n) begin
                we_cnt++;
                if (sram_dq_oe) begin
                    if (drv_cnt == 0) first_drv = we_cnt;
                    drv_cnt++;
                    pend = sram_dq_o;
                end
            end else if (we_cnt > 0) begin
                chk(we_cnt == EXP_HZ + EXP_DAT, "R2 write pulse cycles", we_cnt, EXP_HZ + EXP_DAT);
                chk(we_cnt * 10 >= 45, "R4 pulse width ns", we_cnt * 10, 45);
                chk((first_drv - 1) * 10 >= 12, "R5 turn-off gap ns", (first_drv - 1) * 10, 12);
                chk(drv_cnt * 10 >= 15, "R5 data setup ns", drv_cnt * 10, 15);
                mem[sram_addr[7:0]] = pend;
                we_cnt = 0; drv_cnt = 0; first_drv = 0;
            end
            if (!sram_ce_n && !sram_oe_n) oe_cnt++;
            else if (oe_cnt > 0) begin
                chk(oe_cnt == EXP_RD, "R2 read phase cycles", oe_cnt, EXP_RD);
                chk(oe_cnt * 10 >= 30, "R3 read access ns", oe_cnt * 10, 30);
                oe_cnt = 0;
            end
            chk(!(sram_dq_oe && mem_drive), "R9 bus contention", {sram_dq_oe, mem_drive}, 0);
        end
    end

    // Cycle reference model: 0 power-up, 1 idle, 2 busy.
    int m_edges = 0, m_st = 0, m_k = 0;
    bit m_wr = 1'b0, m_rsp = 1'b0;
    logic [15:0] m_addr = '0, m_wd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_edges = 0; m_st = 0; m_k = 0; m_rsp = 1'b0;
        end else begin
            m_rsp = 1'b0;
            case (m_st)
                0: begin
                    m_edges++;
                    if (m_edges == EXP_PWR + 1) m_st = 1;
                end
                1: if (req_valid) begin
                    m_st = 2; m_wr = req_write; m_addr = req_addr; m_wd = req_wdata; m_k = 1;
                end
                default: begin
                    m_k++;
                    if (m_k > (m_wr ? EXP_HZ + EXP_DAT + 1 : EXP_RD)) begin
                        m_st = 1;
                        if (!m_wr) m_rsp = 1'b1;
                    end
                end
            endcase
        end
    end

    bit busy, e_ce, e_oe, e_we, e_dq;
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            busy = (m_st == 2);
            e_ce = !(busy && (!m_wr || m_k <= EXP_HZ + EXP_DAT));
            e_oe = !(busy && !m_wr);
            e_we = !(busy && m_wr && m_k <= EXP_HZ + EXP_DAT);
            e_dq = busy && m_wr && m_k > EXP_HZ;
            chk(req_ready == (m_st == 1), m_st == 0 ? "R1 ready" : "R7 ready", req_ready, m_st == 1);
            chk(sram_ce_n == e_ce, m_st == 0 ? "R1 ce_n" : "R8 ce_n", sram_ce_n, e_ce);
            chk(sram_oe_n == e_oe, "R3 oe_n", sram_oe_n, e_oe);
            chk(sram_we_n == e_we, "R4 we_n", sram_we_n, e_we);
            chk(sram_dq_oe == e_dq, "R6 dq_oe", sram_dq_oe, e_dq);
            if (busy) chk(sram_addr == m_addr, "R8 addr", sram_addr, m_addr);
            if (e_dq) chk(sram_dq_o == m_wd, "R5 write data", sram_dq_o, m_wd);
            chk(rsp_valid == m_rsp, "R3 rsp_valid", rsp_valid, m_rsp);
            if (m_rsp) chk(rsp_rdata == sb[m_addr[7:0]], "R3 rdata", rsp_rdata, sb[m_addr[7:0]]);
        end
    end

    task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] dat,
                          input bit junk);
        @(negedge clk);
        while (m_st != 1) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat;
        if (wr) sb[a[7:0]] = dat;
        @(negedge clk);
        if (junk) begin
            // R7: stray request while busy must be ignored
            req_addr = a ^ 16'h00AA; req_wdata = ~dat; req_write = !wr;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (m_st != 1) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'(i * 37 + 5);
            sb[i]  = 16'(i * 37 + 5);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !req_ready,
            "R1 reset state", {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready}, 5'b11100);
        rst_n = 1'b1;
        access(1'b1, 16'h0005, 16'h1234, 1'b0);
        access(1'b1, 16'h0006, 16'hBEEF, 1'b0);
        access(1'b1, 16'h00C8, 16'hFFFF, 1'b0);
        access(1'b1, 16'h0000, 16'h0000, 1'b0);
        access(1'b0, 16'h0005, 16'h0, 1'b0);
        access(1'b0, 16'h0006, 16'h0, 1'b0);
        access(1'b0, 16'h00C8, 16'h0, 1'b0);
        access(1'b0, 16'h0000, 16'h0, 1'b0);
        access(1'b0, 16'h0011, 16'h0, 1'b0);
        access(1'b0, 16'h00FF, 16'h0, 1'b0);
        access(1'b1, 16'h0042, 16'hA5A5, 1'b0);
        access(1'b0, 16'h0042, 16'h0, 1'b0);
        access(1'b1, 16'h0043, 16'h5A5A, 1'b0);
        access(1'b1, 16'h0044, 16'h0F0F, 1'b1);
        access(1'b0, 16'h0043, 16'h0, 1'b1);
        access(1'b0, 16'h0044, 16'h0, 1'b0);
        access(1'b0, 16'h00EE, 16'h0, 1'b0);
        drain();
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

endmodule